// File: doc/BRIEF.md
# Interleaved Four-Bank Block Memory

This block is a word-interleaved memory that serves cache-block reads. The word address space is spread over four banks so that neighbouring words live in neighbouring banks. A block read starts the same row access in every bank at once. After one shared access delay, the four words come back on a one-word bus, one per cycle, in ascending word order. A four-word block therefore costs one address cycle, one access latency and four transfer cycles: 1 + 6 + 4 = 11 cycles. Fetching the words one at a time from a single bank would cost 4 × 8 cycles.

The cache side offers one request at a time on a valid/ready handshake. A request is either a block read or a single-word write. A write touches only the bank that owns the word. It takes the address and access phases and has no data-return phase. The banks are modelled as small synchronous arrays. There is no refresh, no row/column split and no second outstanding request.

Top module: `ilv_mem`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `req_ready` is 1 and `rd_valid` is 0.
- R2: Word address `a` is stored in bank `a mod 4`, at row `a div 4`. A read of block `k` returns words `4k`, `4k+1`, `4k+2` and `4k+3` in that order, so beat `i` carries the word held by bank `i`.
- R3: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. For a read, `rd_valid` is 0 for the first 6 cycles after the accepting edge. It is then 1 for exactly 4 consecutive cycles, starting after the 7th edge following acceptance, one word per beat.
- R4: `rd_last` is 1 only on the fourth beat of a read.
- R5: After an accepted read, `req_ready` stays 0 until the 11th edge following acceptance. After an accepted write, it stays 0 until the 7th edge.
- R6: A request presented while `req_ready` is 0 is ignored. It neither writes a bank nor disturbs the transfer in progress.
- R7: A write stores `req_wdata` at the one word given by `req_addr` and leaves every other word unchanged. `rd_valid` stays 0 for the whole write.
- R8: For a read, the two low bits of `req_addr` have no effect. The block `req_addr div 4` is returned, starting from its word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, able to take a request |
| req_write | input | 1 | 1 = single-word write, 0 = block read |
| req_addr | input | AW (8) | Word address |
| req_wdata | input | DW (32) | Write data |
| rd_valid | output | 1 | Read beat present on `rd_data` |
| rd_data | output | DW (32) | Returned word |
| rd_last | output | 1 | Final beat of the block |

## Verification
The assertions assume that `req_valid` is a plain level from the cache side. They also assume that the bench does not rely on acceptance in any cycle where `req_ready` is low, so a request that is held or offered while busy is simply dropped. The stimulus drives every input on the falling edge. It offers a request only after it has seen `req_ready` high, except in the one deliberate test that offers a write while a read is streaming. Every word is written before any read, so no bank row is ever returned uninitialised.

// File: rtl/ilv_mem.sv
module ilv_mem #(
  parameter int NBANK  = 4,
  parameter int DW     = 32,
  parameter int AW     = 8,
  parameter int T_ADDR = 1,
  parameter int T_ACC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);
  localparam int BW    = $clog2(NBANK);
  localparam int RW    = AW - BW;
  localparam int DEPTH = 1 << RW;
  localparam int MAXC  = (T_ACC > NBANK) ? ((T_ACC > T_ADDR) ? T_ACC : T_ADDR)
                                         : ((NBANK > T_ADDR) ? NBANK : T_ADDR);
  localparam int CW    = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACC, S_XFER} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           op_wr;
  logic [AW-1:0]  op_addr;
  logic [DW-1:0]  op_wdata;
  logic           fin_acc;
  logic [DW-1:0]  bank_q [NBANK];

  assign req_ready = (st == S_IDLE);
  assign rd_valid  = (st == S_XFER);
  assign rd_last   = rd_valid && (cnt == CW'(NBANK - 1));
  assign rd_data   = bank_q[cnt[BW-1:0]];
  assign fin_acc   = (st == S_ACC) && (cnt == CW'(T_ACC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st       <= S_ADDR;
          cnt      <= '0;
          op_wr    <= req_write;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
        end
        S_ADDR: if (cnt == CW'(T_ADDR - 1)) begin
          st  <= S_ACC;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_ACC: if (fin_acc) begin
          st  <= op_wr ? S_IDLE : S_XFER;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: if (cnt == CW'(NBANK - 1)) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] line_q;
    always_ff @(posedge clk) begin
      if (fin_acc) begin
        if (op_wr && op_addr[BW-1:0] == BW'(b))
          mem[op_addr[AW-1:BW]] <= op_wdata;
        if (!op_wr)
          line_q <= mem[op_addr[AW-1:BW]];
      end
    end
    assign bank_q[b] = line_q;
  end
endmodule

// File: rtl/ilv_mem_chk.sv
module ilv_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic rd_last
);
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !req_ready); // R5
  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> rd_valid); // R4
  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n) rd_last |=> !rd_valid && req_ready); // R3
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R6
  AST_NO_EARLY_DATA: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !rd_valid); // R3
endmodule

bind ilv_mem ilv_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .rd_last(rd_last)
);

// File: tb/ilv_mem_test.sv
module ilv_mem_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rd_valid, rd_last;
  logic [31:0] rd_data;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] model [256];

  always #10 clk = ~clk;

  ilv_mem uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'(a) * 32'h0100_0193) ^ 32'(s * 32'h1357_9BDF) ^ 32'h5A5A_00C3;
  endfunction

  task automatic do_write(input int a, input logic [31:0] d);
    @(negedge clk);
    chk(req_ready, "R5 ready before write", {31'b0, req_ready}, 1);
    req_valid = 1; req_write = 1; req_addr = 8'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    model[a] = d;
    for (int k = 1; k <= 7; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!rd_valid, "R7 no data on write", {31'b0, rd_valid}, 0);
      chk(req_ready == (k == 7), "R5 write busy window", {31'b0, req_ready}, {31'b0, k == 7});
    end
  endtask

  task automatic do_read(input int blk, input int lo, input bit inject, input int inj_a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'(blk * 4 + lo); req_wdata = 32'hDEAD_BEEF;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    for (int k = 1; k <= 11; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= 7 && k <= 10) begin
        chk(rd_valid, "R3 beat present", {31'b0, rd_valid}, 1);
        chk(rd_data == model[blk * 4 + k - 7], "R2 R8 word order", rd_data, model[blk * 4 + k - 7]);
        chk(rd_last == (k == 10), "R4 last flag", {31'b0, rd_last}, {31'b0, k == 10});
      end else begin
        chk(!rd_valid && !rd_last, "R3 quiet cycle", {30'b0, rd_valid, rd_last}, 0);
      end
      chk(req_ready == (k == 11), "R5 read busy window", {31'b0, req_ready}, {31'b0, k == 11});
      if (inject && k == 3) begin
        req_valid = 1; req_write = 1; req_addr = 8'(inj_a); req_wdata = ~model[inj_a];
      end
      if (inject && k == 5) req_valid = 0;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 reset state", {30'b0, req_ready, rd_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 after reset", {30'b0, req_ready, rd_valid}, 2);

    for (int a = 0; a < 256; a++) do_write(a, pat(a, 0));
    for (int b = 0; b < 64; b++) do_read(b, b % 4, 0, 0);

    do_write(22, pat(22, 1));
    for (int b = 4; b < 7; b++) do_read(b, 3 - (b % 4), 0, 0);

    do_read(9, 0, 1, 37);
    do_read(9, 1, 0, 0);

    for (int a = 0; a < 256; a += 5) do_write(a, pat(a, 2));
    for (int b = 0; b < 64; b++) do_read(b, (b + 1) % 4, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule